// File: doc/BRIEF.md
# Invalid Address Range Tracker

This block keeps a small, fully associative table of cache-line ranges whose contents are known to be dead. Examples are freshly allocated but not yet written heap space, or regions that a collector has found unreachable. A cache controller presents the byte address of every store. In the same cycle the block answers whether that line lies in a tracked dead range. On a hit the line may be installed without fetching it from memory, and the dead line need not be written back later. After any hit the block shrinks or splits the matching range, because the line is about to hold real data.

Software declares dead spans and live spans through a four-slot write-only register interface, using full byte addresses. A dead span commits as a new table entry. A live span is carved out of whatever entries it touches. The table only ever loses coverage conservatively: dropping an entry may miss some dead lines, but no live line is ever reported as dead. Each entry is an arbitrary [base, bound) range of line addresses, not a tag. When a slot is needed and none is free, the entry covering the fewest lines is replaced.

Top module: `irt_tracker`

## Requirements
- R1: The line address is the store byte address shifted right by 6 (64-byte lines). `hit_o` is high in the same cycle that `st_valid_i` is high, if and only if some live entry satisfies base <= line < bound (the bound is exclusive). The register select encodings are 0 for the dead-span base, 1 for the dead-span bound (which commits), 2 for the live-span base and 3 for the live-span bound (which commits).
- R2: On a dead-span commit, the latched base is rounded up and the written bound is rounded down to a line. Only lines wholly inside the span become tracked. A span that contains no whole line changes nothing.
- R3: A dead-span commit releases every entry lying fully inside the new span. It trims any entry that partly overlaps the span so that the entry stays outside it. If an existing entry already contains the whole span, the commit adds nothing.
- R4: A store hit on the first line of an entry moves that entry's base to line+1. A hit on its last line (when this is not also its first line) moves the bound to the line. An entry left with base equal to bound becomes unused.
- R5: A store hit strictly inside an entry splits it. The entry keeps [base, line), and the replacement slot receives [line+1, old bound).
- R6: On a live-span commit, the latched base is rounded down and the written bound is rounded up to a line. Every tracked line in that span is removed. An entry containing the whole span is split, an entry partly overlapping it is trimmed at the overlapping end, and a fully covered entry is released.
- R7: The replacement slot is the lowest-index unused entry. If every entry is in use, it is the entry with the fewest lines, with the lowest index winning a tie. Lines of an evicted range no longer hit.
- R8: A register write in the same cycle as a store is ignored. This applies to base latches as well as commits.
- R9: After reset no entry is in use and no store hits.
- R10: Tracked ranges never overlap, so at most one entry matches any line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 dead base, 1 dead bound, 2 live base, 3 live bound) |
| reg_wdata_i | input | ADDR_W | Byte address written to the selected register |
| st_valid_i | input | 1 | Store lookup request |
| st_addr_i | input | ADDR_W | Byte address of the store |
| hit_o | output | 1 | Store line lies in a tracked dead range |

## Verification
Stores are aimed at the first line, the last line, an interior line and the line just outside each range. A repeated store to the same line then separates the base trim, the bound trim and the split from one another. Dead-span commits with unaligned addresses, with no whole line, and nested around or inside existing entries show whether the rounding and overlap cleanup are applied. A live-span carve distinguishes the rounding direction from trimming. Filling a four-entry table and committing once more shows which entry is evicted, and a store and a commit in the same cycle shows that the write is dropped. A behavioural model follows every cycle, so every later store also probes the table's hidden state.

// File: rtl/irt_pkg.sv
package irt_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_DEL  = 2'd2
  } irt_op_e;

  localparam logic [1:0] SEL_DEAD_BASE = 2'd0;
  localparam logic [1:0] SEL_DEAD_BND  = 2'd1;
  localparam logic [1:0] SEL_LIVE_BASE = 2'd2;
  localparam logic [1:0] SEL_LIVE_BND  = 2'd3;
endpackage

// File: rtl/irt_span.sv
module irt_span
  import irt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LOFF   = 6,
  localparam int LINE_W = ADDR_W - LOFF + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  output irt_op_e           op_o,
  output logic [LINE_W-1:0] lo_o,
  output logic [LINE_W-1:0] hi_o,
  output logic [LINE_W-1:0] st_line_o
);
  localparam logic [ADDR_W:0] RND = (ADDR_W+1)'((1 << LOFF) - 1);

  logic [LINE_W-1:0] tmp_q;
  logic [ADDR_W:0]   wext;
  logic [LINE_W-1:0] rnd_up, rnd_dn;

  assign wext      = {1'b0, reg_wdata_i} + RND;
  assign rnd_up    = wext[ADDR_W:LOFF];
  assign rnd_dn    = {1'b0, reg_wdata_i[ADDR_W-1:LOFF]};
  assign st_line_o = {1'b0, st_addr_i[ADDR_W-1:LOFF]};

  always_comb begin
    op_o = OP_NONE;
    lo_o = '0;
    hi_o = '0;
    if (st_valid_i) begin
      op_o = OP_DEL;
      lo_o = st_line_o;
      hi_o = st_line_o + 1'b1;
    end else if (reg_we_i && reg_sel_i == SEL_DEAD_BND) begin
      lo_o = tmp_q;
      hi_o = rnd_dn;
      op_o = (tmp_q < rnd_dn) ? OP_ADD : OP_NONE;
    end else if (reg_we_i && reg_sel_i == SEL_LIVE_BND) begin
      lo_o = tmp_q;
      hi_o = rnd_up;
      op_o = (tmp_q < rnd_up) ? OP_DEL : OP_NONE;
    end
  end

  // dead base rounds inward (up), live base rounds outward (down)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tmp_q <= '0;
    else if (reg_we_i && !st_valid_i) begin
      if (reg_sel_i == SEL_DEAD_BASE) tmp_q <= rnd_up;
      else if (reg_sel_i == SEL_LIVE_BASE) tmp_q <= rnd_dn;
    end
  end

  assert_reg_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && reg_we_i) |=> $stable(tmp_q));
endmodule

// File: rtl/irt_entry.sv
module irt_entry
  import irt_pkg::*;
#(
  parameter int LINE_W = 27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  irt_op_e           op_i,
  input  logic [LINE_W-1:0] lo_i,
  input  logic [LINE_W-1:0] hi_i,
  input  logic [LINE_W-1:0] st_line_i,
  input  logic              alloc_we_i,
  input  logic [LINE_W-1:0] alloc_base_i,
  input  logic [LINE_W-1:0] alloc_bound_i,
  output logic              valid_o,
  output logic [LINE_W-1:0] base_o,
  output logic [LINE_W-1:0] bound_o,
  output logic              hit_o,
  output logic              split_o,
  output logic              contain_o
);
  logic              valid_q, valid_d;
  logic [LINE_W-1:0] base_q, base_d, bound_q, bound_d;
  logic              ovl, covered, inner, holds;

  assign valid_o = valid_q;
  assign base_o  = base_q;
  assign bound_o = bound_q;
  assign hit_o   = valid_q && base_q <= st_line_i && st_line_i < bound_q;

  assign ovl     = valid_q && lo_i < bound_q && hi_i > base_q;
  assign covered = lo_i <= base_q && hi_i >= bound_q;
  assign inner   = lo_i > base_q && hi_i < bound_q;
  assign holds   = base_q <= lo_i && bound_q >= hi_i;

  always_comb begin
    split_o   = ovl && op_i == OP_DEL && inner;
    contain_o = ovl && op_i == OP_ADD && holds && !covered;
  end

  always_comb begin
    valid_d = valid_q;
    base_d  = base_q;
    bound_d = bound_q;
    if (ovl && op_i != OP_NONE) begin
      if (covered) valid_d = 1'b0;
      else if (op_i == OP_DEL && inner) bound_d = lo_i;
      else if (op_i == OP_ADD && holds) valid_d = valid_q;
      else if (lo_i > base_q) bound_d = lo_i;
      else base_d = hi_i;
    end
    if (alloc_we_i) begin
      valid_d = 1'b1;
      base_d  = alloc_base_i;
      bound_d = alloc_bound_i;
    end
    if (base_d >= bound_d) valid_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      base_q  <= '0;
      bound_q <= '0;
    end else begin
      valid_q <= valid_d;
      base_q  <= base_d;
      bound_q <= bound_d;
    end
  end

  assert_live_nonempty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> base_q < bound_q);
endmodule

// File: rtl/irt_victim.sv
module irt_victim #(
  parameter int NUM_ENT = 256,
  parameter int LINE_W  = 27,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic [NUM_ENT-1:0]             valid_i,
  input  logic [NUM_ENT-1:0][LINE_W-1:0] base_i,
  input  logic [NUM_ENT-1:0][LINE_W-1:0] bound_i,
  output logic [IDX_W-1:0]               idx_o
);
  logic              any_free, have_min;
  logic [IDX_W-1:0]  free_idx, min_idx;
  logic [LINE_W-1:0] min_sz, sz;

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    have_min = 1'b0;
    min_idx  = '0;
    min_sz   = '0;
    sz       = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (!valid_i[i]) begin
        if (!any_free) free_idx = IDX_W'(i);
        any_free = 1'b1;
      end else begin
        sz = bound_i[i] - base_i[i];
        if (!have_min || sz < min_sz) begin
          min_sz  = sz;
          min_idx = IDX_W'(i);
        end
        have_min = 1'b1;
      end
    end
    idx_o = any_free ? free_idx : min_idx;
  end
endmodule

// File: rtl/irt_tracker.sv
module irt_tracker
  import irt_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LOFF    = 6,
  parameter int NUM_ENT = 256,
  localparam int LINE_W = ADDR_W - LOFF + 1,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  output logic              hit_o
);
  irt_op_e           op;
  logic [LINE_W-1:0] lo, hi, st_line;

  logic [NUM_ENT-1:0]             valid_v, hit_v, split_v, contain_v;
  logic [NUM_ENT-1:0][LINE_W-1:0] base_a, bound_a;
  logic [IDX_W-1:0]               victim;
  logic                           alloc_en;
  logic [LINE_W-1:0]              alloc_base, alloc_bound, split_bound;

  irt_span #(.ADDR_W(ADDR_W), .LOFF(LOFF)) u_span (
    .clk_i, .rst_ni, .reg_we_i, .reg_sel_i, .reg_wdata_i,
    .st_valid_i, .st_addr_i,
    .op_o(op), .lo_o(lo), .hi_o(hi), .st_line_o(st_line)
  );

  irt_victim #(.NUM_ENT(NUM_ENT), .LINE_W(LINE_W)) u_victim (
    .valid_i(valid_v), .base_i(base_a), .bound_i(bound_a), .idx_o(victim)
  );

  always_comb begin
    split_bound = '0;
    for (int i = 0; i < NUM_ENT; i++)
      if (split_v[i]) split_bound = split_bound | bound_a[i];
  end

  assign alloc_en    = (op == OP_ADD && !(|contain_v)) || (op == OP_DEL && (|split_v));
  assign alloc_base  = (op == OP_ADD) ? lo : hi;
  assign alloc_bound = (op == OP_ADD) ? hi : split_bound;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    irt_entry #(.LINE_W(LINE_W)) u_ent (
      .clk_i, .rst_ni,
      .op_i(op), .lo_i(lo), .hi_i(hi), .st_line_i(st_line),
      .alloc_we_i(alloc_en && victim == IDX_W'(g)),
      .alloc_base_i(alloc_base), .alloc_bound_i(alloc_bound),
      .valid_o(valid_v[g]), .base_o(base_a[g]), .bound_o(bound_a[g]),
      .hit_o(hit_v[g]), .split_o(split_v[g]), .contain_o(contain_v[g])
    );
  end

  assign hit_o = st_valid_i && (|hit_v);

  // checking support
  function automatic logic tracked(input logic [LINE_W-1:0] ln,
                                   input logic [NUM_ENT-1:0] v,
                                   input logic [NUM_ENT-1:0][LINE_W-1:0] b,
                                   input logic [NUM_ENT-1:0][LINE_W-1:0] e);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_ENT; i++)
      if (v[i] && b[i] <= ln && ln < e[i]) r = 1'b1;
    return r;
  endfunction

  logic              st_hit_q, add_q;
  logic [LINE_W-1:0] st_line_q, add_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_hit_q  <= 1'b0;
      add_q     <= 1'b0;
      st_line_q <= '0;
      add_lo_q  <= '0;
    end else begin
      st_hit_q  <= hit_o;
      st_line_q <= st_line;
      add_q     <= (op == OP_ADD);
      add_lo_q  <= lo;
    end
  end

  assert_single_match_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_valid_i |-> $onehot0(hit_v));

  assert_line_released_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_hit_q |-> !tracked(st_line_q, valid_v, base_a, bound_a));

  assert_commit_tracked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_q |-> tracked(add_lo_q, valid_v, base_a, bound_a));

  assert_reset_empty_R9: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> valid_v == '0);
endmodule

// File: tb/sim_irt_tracker.sv
`timescale 1ns/1ps
module sim_irt_tracker;
  localparam int AW = 32;
  localparam int NE = 4;
  localparam int LW = AW - 6 + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_sel = 2'd0;
  logic [AW-1:0] reg_wdata = '0;
  logic          st_valid = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic          hit;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irt_tracker #(.ADDR_W(AW), .LOFF(6), .NUM_ENT(NE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .st_valid_i(st_valid), .st_addr_i(st_addr), .hit_o(hit)
  );

  // reference model
  bit          mv[NE];
  logic [LW-1:0] mb[NE], me[NE];
  logic [LW-1:0] mtmp = '0;

  function automatic logic [LW-1:0] up(input logic [AW-1:0] a);
    logic [AW:0] s;
    s = {1'b0, a} + 33'd63;
    return s[AW:6];
  endfunction

  function automatic logic [LW-1:0] dn(input logic [AW-1:0] a);
    return {1'b0, a[AW-1:6]};
  endfunction

  function automatic bit m_hit(input logic [LW-1:0] ln);
    for (int i = 0; i < NE; i++)
      if (mv[i] && mb[i] <= ln && ln < me[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int m_victim();
    int best;
    best = -1;
    for (int i = 0; i < NE; i++) if (!mv[i]) return i;
    for (int i = 0; i < NE; i++)
      if (best < 0 || (me[i] - mb[i]) < (me[best] - mb[best])) best = i;
    return best;
  endfunction

  // kind 1 = add dead span, 2 = remove span
  task automatic m_apply(input int kind, input logic [LW-1:0] lo, input logic [LW-1:0] hi);
    int v;
    bit nw, cont;
    logic [LW-1:0] nb, ne_;
    if (lo >= hi) return;
    v = m_victim();
    nw = 0; cont = 0; nb = '0; ne_ = '0;
    if (kind == 1)
      for (int i = 0; i < NE; i++)
        if (mv[i] && mb[i] <= lo && me[i] >= hi) cont = 1;
    for (int i = 0; i < NE; i++) begin
      if (mv[i] && lo < me[i] && hi > mb[i]) begin
        if (lo <= mb[i] && hi >= me[i]) mv[i] = 0;
        else if (kind == 2 && lo > mb[i] && hi < me[i]) begin
          nw = 1; nb = hi; ne_ = me[i]; me[i] = lo;
        end else if (kind == 1 && mb[i] <= lo && me[i] >= hi) begin
        end else if (lo > mb[i]) me[i] = lo;
        else mb[i] = hi;
      end
    end
    if (kind == 1 && !cont) begin nw = 1; nb = lo; ne_ = hi; end
    if (nw) begin mv[v] = 1; mb[v] = nb; me[v] = ne_; end
    for (int i = 0; i < NE; i++) if (mb[i] >= me[i]) mv[i] = 0;
  endtask

  task automatic check(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: hit_o=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit we, input logic [1:0] sel, input logic [AW-1:0] wd,
                     input bit st, input logic [AW-1:0] sa, input string tag);
    @(negedge clk);
    reg_we = we; reg_sel = sel; reg_wdata = wd; st_valid = st; st_addr = sa;
    #1;
    check(hit, st && m_hit(dn(sa)), tag);
    if (st) m_apply(2, dn(sa), dn(sa) + 1'b1);
    else if (we) begin
      case (sel)
        2'd0: mtmp = up(wd);
        2'd1: m_apply(1, mtmp, dn(wd));
        2'd2: mtmp = dn(wd);
        2'd3: m_apply(2, mtmp, up(wd));
        default: ;
      endcase
    end
  endtask

  task automatic store(input logic [AW-1:0] a, input string tag);
    cyc(1'b0, 2'd0, '0, 1'b1, a, tag);
  endtask

  task automatic wr(input logic [1:0] s, input logic [AW-1:0] d, input string tag);
    cyc(1'b1, s, d, 1'b0, '0, tag);
  endtask

  task automatic dead(input logic [AW-1:0] b, input logic [AW-1:0] e, input string tag);
    wr(2'd0, b, tag);
    wr(2'd1, e, tag);
  endtask

  task automatic live(input logic [AW-1:0] b, input logic [AW-1:0] e, input string tag);
    wr(2'd2, b, tag);
    wr(2'd3, e, tag);
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) begin mv[i] = 0; mb[i] = '0; me[i] = '0; end
    repeat (3) @(negedge clk);
    #1 check(hit, 1'b0, "R9 in reset");
    rst_n = 1'b1;
    store(32'h0000_1000, "R9 empty after reset");

    // R2: rounding inward -> lines 0x41..0x4F
    dead(32'h0000_1010, 32'h0000_1400, "R2 commit");
    store(32'h0000_1000, "R2 below rounded base");
    store(32'h0000_1400, "R2 at exclusive bound");
    // R4 edges
    store(32'h0000_1040, "R4 base edge hit");
    store(32'h0000_1040, "R4 base edge released");
    store(32'h0000_13C0, "R4 bound edge hit");
    store(32'h0000_13C0, "R4 bound edge released");
    // R5 split
    store(32'h0000_1200, "R5 interior hit");
    store(32'h0000_1200, "R5 split line gone");
    store(32'h0000_11C0, "R5 lower half kept");
    store(32'h0000_1240, "R5 upper half kept");
    // R1 line granularity: same line, different byte
    store(32'h0000_1285, "R1 byte within line");
    store(32'h0000_12BF, "R1 same line after trim");

    // R6 outward rounding: lines 0x42..0x43 removed
    live(32'h0000_1090, 32'h0000_10C1, "R6 commit");
    store(32'h0000_1080, "R6 removed low");
    store(32'h0000_10C0, "R6 removed high");
    store(32'h0000_1100, "R6 untouched");
    // R6 partial overlap trim then inside split
    live(32'h0000_1300, 32'h0000_1500, "R6 partial");
    store(32'h0000_12C0, "R6 kept below span");
    store(32'h0000_1300, "R6 trimmed end");

    // R4 single-line range becomes unused
    dead(32'h0000_5000, 32'h0000_5040, "R4 single line");
    store(32'h0000_5000, "R4 single hit");
    store(32'h0000_5000, "R4 single released");
    // R2 span without a whole line
    dead(32'h0000_6010, 32'h0000_6040, "R2 empty span");
    store(32'h0000_6000, "R2 empty not tracked");

    // clear everything
    live(32'h0000_0000, 32'hFFFF_FF00, "R6 clear all");
    store(32'h0000_1140, "R6 cleared");

    // R3 nesting
    dead(32'h0000_2000, 32'h0000_2400, "R3 inner");
    dead(32'h0000_1F00, 32'h0000_2800, "R3 outer covers");
    store(32'h0000_1F00, "R3 outer base");
    dead(32'h0000_2100, 32'h0000_2200, "R3 already contained");
    store(32'h0000_2140, "R3 contained interior");
    dead(32'h0000_2700, 32'h0000_2C00, "R3 partial overlap");
    store(32'h0000_2BC0, "R3 new tail");
    store(32'h0000_26C0, "R3 old tail kept");
    store(32'h0000_2840, "R3 overlap region");

    // R8 simultaneous store and register write
    live(32'h0000_0000, 32'hFFFF_FF00, "R8 clear");
    wr(2'd0, 32'h0000_7000, "R8 base");
    cyc(1'b1, 2'd1, 32'h0000_8000, 1'b1, 32'h0000_9000, "R8 commit dropped");
    store(32'h0000_7000, "R8 nothing committed");
    cyc(1'b1, 2'd0, 32'h0000_A000, 1'b1, 32'h0000_9000, "R8 base dropped");
    wr(2'd1, 32'h0000_7400, "R8 old base used");
    store(32'h0000_7100, "R8 commit from old base");

    // R7 eviction with four slots
    live(32'h0000_0000, 32'hFFFF_FF00, "R7 clear");
    dead(32'h0001_0000, 32'h0001_0200, "R7 fill 8");
    dead(32'h0002_0000, 32'h0002_0080, "R7 fill 2");
    dead(32'h0003_0000, 32'h0003_0400, "R7 fill 16");
    dead(32'h0004_0000, 32'h0004_0080, "R7 fill 2 tie");
    dead(32'h0005_0000, 32'h0005_0100, "R7 evict");
    store(32'h0002_0040, "R7 smallest evicted");
    store(32'h0004_0040, "R7 tie later kept");
    store(32'h0005_0000, "R7 new entry");
    store(32'h0003_0200, "R7 split when full");
    store(32'h0003_0240, "R7 upper after full split");
    store(32'h0001_0000, "R7 other entry");
    // R10: neighbouring lines each match once
    store(32'h0003_01C0, "R10 adjacent");
    store(32'h0003_0280, "R10 adjacent");

    cyc(1'b0, 2'd0, '0, 1'b0, '0, "R1 idle");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule